// File: doc/BRIEF.md
# Agree-Mode Branch Direction Predictor

This block predicts the direction of conditional branches for a fetch stage. It keeps a small tagged table of per-branch bias bits, indexed by the low bits of the branch address and holding the rest of the address as a tag. It also keeps a shared table of 2-bit saturating counters, indexed by the global outcome history XORed with the address. The counters do not learn taken or not-taken. They learn whether a branch tends to follow its own bias bit. The predicted direction is the bias bit when the counter's upper bit is set, and the inverted bias bit when it is clear.

Two branches that alias onto the same counter but lean in opposite directions therefore both push that counter the same way, which keeps them from fighting over it. A branch gets its bias entry the first time it resolves, and the bias it receives is that first outcome. The bias never changes while the entry lives. A branch with no entry is predicted not-taken and reported as a miss.

Every cycle the block looks up `pred_pc` and registers the result. Whenever `upd_valid` is high it trains on a resolved branch (`upd_pc`, `upd_taken`) and shifts the outcome into the global history.

Top module: `agree_pred`

## Requirements
- R1: After synchronous reset, every bias entry is invalid, every counter holds the weak-agree value 2'b10, and the global history is all zeros.
- R2: `pred_hit` and `pred_taken` are registered. They reflect the `pred_pc` sampled at a rising clock edge and the table state from before that edge, and they change only at that edge.
- R3: When the bias entry selected by `pred_pc[3:0]` is invalid or its tag (`pred_pc[15:4]`) differs, `pred_hit` is 0 and `pred_taken` is 0.
- R4: An update whose address misses the bias table allocates the entry at index `upd_pc[3:0]`, storing tag `upd_pc[15:4]` and bias equal to `upd_taken`. That outcome counts as agreeing with the bias.
- R5: An update whose address hits the bias table leaves the stored bias bit unchanged, whatever the outcome.
- R6: On each update, the counter at index `hist ^ upd_pc[5:0]` (history as it was before this update) rises by one if the outcome equals the bias and falls by one otherwise. It saturates at 3 and at 0.
- R7: On a hit, `pred_taken` equals the bias bit when bit 1 of the counter at `hist ^ pred_pc[5:0]` is 1, and equals the inverted bias bit when that bit is 0.
- R8: Each valid update shifts the global history left by one and inserts `upd_taken` at bit 0. When `upd_valid` is 0, `upd_pc` and `upd_taken` change no state.
- R9: An allocation at an index already holding another tag replaces that entry, and the replaced branch then misses.
- R10: Two branches with opposite biases that resolve in their biased directions on the same counter both move that counter toward agree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | 16 | Address of the branch to predict |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 16 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| pred_hit | output | 1 | Registered: the predicted address has a bias entry |
| pred_taken | output | 1 | Registered: predicted direction, 1 = taken |

## Verification
Single branches are trained with runs of agreeing outcomes and then runs of disagreeing outcomes. Filler updates bring the history back to zero between steps, so that the ceiling, the hysteresis step, the inversion point and the floor of one counter can each be seen in the prediction. A pair of branches with opposite biases, steered by all-zero and all-one histories onto the same counter, shows the agree-based scheme apart from a plain direction counter. That plain counter would predict the wrong direction for one of the two branches. Tag conflicts at one bias index, inputs presented with the valid signal low, and a long mixed stream of concurrent predictions and updates compared against a bench model cover replacement, ignored inputs and the dependence on history.

// File: rtl/agree_pkg.sv
package agree_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_AGREE = 2'b10;
  localparam ctr_t CTR_MAX        = 2'b11;
  localparam ctr_t CTR_MIN        = 2'b00;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic agree);
    ctr_t nxt;
    if (agree) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/agree_hist.sv
module agree_hist #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
  end

  assign hist = hist_q;

  assert_hist_shift_R8: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist_q[0] == $past(bit_in)) &&
                 (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

  assert_hist_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/agree_bias_tbl.sv
module agree_bias_tbl #(
  parameter int PC_W  = 16,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic            rd_bias,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_taken,
  output logic            wr_hit,
  output logic            wr_bias
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_mem  [DEPTH];
  logic             bias_mem [DEPTH];

  logic [IDX_W-1:0] r_idx, w_idx;
  logic [TAG_W-1:0] r_tag, w_tag;
  logic             alloc;

  assign r_idx = rd_pc[IDX_W-1:0];
  assign r_tag = rd_pc[PC_W-1:IDX_W];
  assign w_idx = wr_pc[IDX_W-1:0];
  assign w_tag = wr_pc[PC_W-1:IDX_W];

  assign rd_hit  = vld_q[r_idx] && (tag_mem[r_idx] == r_tag);
  assign rd_bias = bias_mem[r_idx];
  assign wr_hit  = vld_q[w_idx] && (tag_mem[w_idx] == w_tag);
  assign wr_bias = wr_hit ? bias_mem[w_idx] : wr_taken;
  assign alloc   = wr_en && !wr_hit;

  // valid bits live in flops so reset can clear them in one cycle
  always_ff @(posedge clk) begin
    if (rst)        vld_q <= '0;
    else if (alloc) vld_q[w_idx] <= 1'b1;
  end

  // tag and bias storage carries no reset, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (alloc) begin
      tag_mem[w_idx]  <= w_tag;
      bias_mem[w_idx] <= wr_taken;
    end
  end

  assert_alloc_bias_R4: assert property (@(posedge clk) disable iff (rst)
    alloc |=> vld_q[$past(w_idx)] && (bias_mem[$past(w_idx)] == $past(wr_taken)));

  assert_bias_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hit) |=> bias_mem[$past(w_idx)] == $past(bias_mem[w_idx]));

  assert_replace_tag_R9: assert property (@(posedge clk) disable iff (rst)
    alloc |=> tag_mem[$past(w_idx)] == $past(w_tag));
endmodule

// File: rtl/agree_ctr_tbl.sv
module agree_ctr_tbl
  import agree_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_agree,
  output ctr_t             wr_cur
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_cur = ctr_q[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WEAK_AGREE;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= ctr_step(wr_cur, wr_agree);
    end
  end

  assert_ctr_up_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_agree && wr_cur != CTR_MAX) |=>
      ctr_q[$past(wr_idx)] == ctr_t'($past(wr_cur) + 2'd1));

  assert_ctr_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_agree && wr_cur == CTR_MAX) |=> ctr_q[$past(wr_idx)] == CTR_MAX);

  assert_ctr_down_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_agree && wr_cur != CTR_MIN) |=>
      ctr_q[$past(wr_idx)] == ctr_t'($past(wr_cur) - 2'd1));

  assert_ctr_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_agree && wr_cur == CTR_MIN) |=> ctr_q[$past(wr_idx)] == CTR_MIN);
endmodule

// File: rtl/agree_pred.sv
module agree_pred
  import agree_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int HIST_W     = 6,
  parameter int BIAS_IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic            pred_hit,
  output logic            pred_taken
);
  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] rd_idx, wr_idx;
  logic              rd_hit, rd_bias, wr_hit, wr_bias, wr_agree;
  ctr_t              rd_ctr, wr_cur;

  assign rd_idx   = hist ^ pred_pc[HIST_W-1:0];
  assign wr_idx   = hist ^ upd_pc[HIST_W-1:0];
  assign wr_agree = (upd_taken == wr_bias);

  agree_hist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist     (hist)
  );

  agree_bias_tbl #(.PC_W(PC_W), .IDX_W(BIAS_IDX_W)) u_bias (
    .clk      (clk),
    .rst      (rst),
    .rd_pc    (pred_pc),
    .rd_hit   (rd_hit),
    .rd_bias  (rd_bias),
    .wr_en    (upd_valid),
    .wr_pc    (upd_pc),
    .wr_taken (upd_taken),
    .wr_hit   (wr_hit),
    .wr_bias  (wr_bias)
  );

  agree_ctr_tbl #(.IDX_W(HIST_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (wr_idx),
    .wr_agree (wr_agree),
    .wr_cur   (wr_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_hit   <= 1'b0;
      pred_taken <= 1'b0;
    end else begin
      pred_hit   <= rd_hit;
      pred_taken <= rd_hit & (rd_ctr[1] ? rd_bias : ~rd_bias);
    end
  end

  assert_miss_not_taken_R3: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> !pred_taken);

  assert_update_allocates_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !wr_hit) |=> u_bias.vld_q[$past(upd_pc[BIAS_IDX_W-1:0])]);
endmodule

// File: tb/sim_agree_pred.sv
module sim_agree_pred;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pred_pc = '0;
  logic        upd_valid = 1'b0;
  logic [15:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pred_hit, pred_taken;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  agree_pred u0 (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .pred_hit(pred_hit), .pred_taken(pred_taken)
  );

  // bench model built from the requirements
  bit         m_val  [16];
  logic [11:0] m_tag [16];
  bit         m_bias [16];
  logic [1:0] m_ctr  [64];
  logic [5:0] m_hist;

  function automatic void m_reset();
    for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_tag[i] = '0; m_bias[i] = 0; end
    for (int i = 0; i < 64; i++) m_ctr[i] = 2'b10;
    m_hist = '0;
  endfunction

  function automatic void m_expect(input logic [15:0] pc, output bit eh, output bit et);
    logic [1:0] c;
    eh = m_val[pc[3:0]] && (m_tag[pc[3:0]] == pc[15:4]);
    c  = m_ctr[m_hist ^ pc[5:0]];
    et = eh && (c[1] ? m_bias[pc[3:0]] : !m_bias[pc[3:0]]);
  endfunction

  function automatic void m_update(input logic [15:0] pc, input bit t);
    bit h, b;
    logic [5:0] ci;
    h = m_val[pc[3:0]] && (m_tag[pc[3:0]] == pc[15:4]);
    if (!h) begin
      m_val[pc[3:0]] = 1; m_tag[pc[3:0]] = pc[15:4]; m_bias[pc[3:0]] = t;
    end
    b  = m_bias[pc[3:0]];
    ci = m_hist ^ pc[5:0];
    if (t == b) begin if (m_ctr[ci] != 2'b11) m_ctr[ci] = m_ctr[ci] + 2'd1; end
    else        begin if (m_ctr[ci] != 2'b00) m_ctr[ci] = m_ctr[ci] - 2'd1; end
    m_hist = {m_hist[4:0], t};
  endfunction

  task automatic check(input string req, input string what, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; upd_valid = 1'b0; pred_pc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_reset();
  endtask

  task automatic upd(input logic [15:0] pc, input bit t);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
    m_update(pc, t);
    @(posedge clk); @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic pred_chk(input logic [15:0] pc, input bit eh, input bit et, input string req);
    pred_pc = pc;
    @(posedge clk); @(negedge clk);
    check(req, "pred_hit", pred_hit, eh);
    check(req, "pred_taken", pred_taken, et);
  endtask

  // six not-taken updates of a filler branch bring the history to zero
  task automatic flush0();
    for (int i = 0; i < 6; i++) upd(16'h0F0E, 1'b0);
  endtask

  task automatic t_reset_state();
    do_reset();
    pred_chk(16'h0000, 0, 0, "R1");
    pred_chk(16'hBEEF, 0, 0, "R3");
  endtask

  task automatic t_latency();
    do_reset();
    pred_pc = 16'h0000;
    upd(16'h1233, 1'b1);
    pred_pc = 16'h1233;
    #1;
    check("R2", "pred_hit before edge", pred_hit, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R2", "pred_hit after edge", pred_hit, 1'b1);
    check("R2", "pred_taken after edge", pred_taken, 1'b1);
  endtask

  task automatic t_alloc();
    do_reset();
    upd(16'h1234, 1'b0);
    pred_chk(16'h1234, 1, 0, "R4");
    upd(16'h5678, 1'b1);
    pred_chk(16'h5678, 1, 1, "R4");
  endtask

  task automatic t_bias_keep();
    do_reset();
    upd(16'h2227, 1'b1);
    upd(16'h2227, 1'b0);
    pred_chk(16'h2227, 1, 1, "R5");
  endtask

  task automatic t_counter();
    do_reset();
    upd(16'h3008, 1'b0);
    upd(16'h3008, 1'b0);
    pred_chk(16'h3008, 1, 0, "R6 ceiling");
    upd(16'h3008, 1'b1);
    flush0();
    pred_chk(16'h3008, 1, 0, "R6 hysteresis");
    upd(16'h3008, 1'b1);
    flush0();
    pred_chk(16'h3008, 1, 1, "R7 inverted bias");
    upd(16'h3008, 1'b1);
    flush0();
    upd(16'h3008, 1'b1);
    flush0();
    pred_chk(16'h3008, 1, 1, "R6 floor");
  endtask

  task automatic t_idle();
    do_reset();
    upd(16'h0123, 1'b1);
    pred_chk(16'h0123, 1, 1, "R8");
    upd_valid = 1'b0; upd_pc = 16'h0777; upd_taken = 1'b0;
    repeat (5) begin @(negedge clk); upd_taken = ~upd_taken; end
    pred_chk(16'h0777, 0, 0, "R8 ignored while invalid");
    pred_chk(16'h0123, 1, 1, "R8 state kept");
  endtask

  task automatic t_conflict();
    do_reset();
    upd(16'h4005, 1'b1);
    pred_chk(16'h4005, 1, 1, "R9");
    upd(16'h5005, 1'b0);
    pred_chk(16'h4005, 0, 0, "R9 replaced");
    pred_chk(16'h5005, 1, 0, "R9 new owner");
  endtask

  task automatic t_alias();
    do_reset();
    upd(16'h0005, 1'b0);
    for (int i = 0; i < 6; i++) upd(16'h0F0E, 1'b1);
    upd(16'h003A, 1'b1);
    pred_chk(16'h003A, 1, 1, "R10 taken-biased");
    flush0();
    pred_chk(16'h0005, 1, 0, "R10 not-taken-biased");
  endtask

  task automatic t_random();
    bit eh, et, u, t;
    logic [15:0] p, q;
    do_reset();
    for (int k = 0; k < 400; k++) begin
      p = {4'h0, 4'($urandom_range(0, 2)), 4'h0, 4'($urandom_range(0, 15))};
      q = {4'h0, 4'($urandom_range(0, 2)), 4'h0, 4'($urandom_range(0, 15))};
      u = 1'($urandom_range(0, 1));
      t = 1'($urandom_range(0, 1));
      pred_pc = p; upd_valid = u; upd_pc = q; upd_taken = t;
      m_expect(p, eh, et);
      if (u) m_update(q, t);
      @(posedge clk); @(negedge clk);
      upd_valid = 1'b0;
      check("R7", "random pred_hit", pred_hit, eh);
      check("R8", "random pred_taken", pred_taken, et);
    end
  endtask

  initial begin
    m_reset();
    t_reset_state();
    t_latency();
    t_alloc();
    t_bias_keep();
    t_counter();
    t_idle();
    t_conflict();
    t_alias();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule